// File: doc/BRIEF.md
# Self-Clearing Software Reset Sequencer

This block holds the software reset control register of an SD/MMC host controller. Software writes a 1 to one or more bits to reset a domain: the whole controller, the command line or the data line. The block then raises that domain's reset output. The bit keeps reading 1 for as long as the reset is in progress. Hardware clears it once two things are true: a minimum pulse length has passed, and the domain has reported through its done input that it has finished. Software can therefore poll the register until the bit reads 0.

A data-line reset is also sent to the DMA engine. While it is active, the block forces the buffer-read-enable status it passes through to 0, so the data buffer is seen as cleared and reinitialised.

A full-controller reset is applied over the two line domains. While bit 0 is busy, the command and data reset outputs are asserted and bits 1 and 2 also read 1.

Top module: `sdhc_swrst_ctrl`

## Requirements
- R1: Register bit positions are fixed: bit 0 is the full reset, bit 1 the command-line reset and bit 2 the data-line reset. A write with a 1 in an idle bit raises that domain's reset output and makes the bit read 1 from the cycle after the write. A 0 in any bit starts nothing.
- R2: Once started, each domain's reset stays asserted for at least MIN_PULSE clock cycles (default 4).
- R3: A domain's bit clears, and its reset drops, at the first clock edge where both of these hold: at least MIN_PULSE cycles have passed, and the domain's done input was high in the current cycle or an earlier cycle of this reset. With done first seen D cycles after the write cycle, the reset lasts max(MIN_PULSE, D+1) cycles.
- R4: While the data-line reset is active (from bit 2 or bit 0), dma_rst_o is high and buf_rden_o is 0. At all other times buf_rden_o follows buf_rden_i.
- R5: Bits 7 to 3 always read 0, and writes to them have no effect. After reset the register reads 0 and all reset outputs are low.
- R6: While the full reset is active, rst_all_o, rst_cmd_o and rst_dat_o are all high and bits 2:0 read 3'b111. Bit 0 clears on all_done_i.
- R7: Writing 1 to a bit that is already set neither restarts nor extends that domain's reset.
- R8: Bits written together start in the same cycle, and each clears on its own done input and timing.
- R9: A done input that is high while its domain is idle has no effect. It neither starts a reset nor shortens a later one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read value: busy bits 2:0, zeros above |
| all_done_i | input | 1 | Full-controller reset has completed |
| cmd_done_i | input | 1 | Command-line reset has completed |
| dat_done_i | input | 1 | Data-line reset has completed |
| buf_rden_i | input | 1 | Buffer-read-enable status from the buffer logic |
| rst_all_o | output | 1 | Full-controller reset |
| rst_cmd_o | output | 1 | Command-line reset |
| rst_dat_o | output | 1 | Data-line and buffer reset |
| dma_rst_o | output | 1 | DMA engine reset |
| buf_rden_o | output | 1 | Buffer-read-enable status, forced to 0 during data reset |

## Verification
Each domain keeps only a busy flag, a small saturating counter and a sticky done flag. A fault in any of them shows up at the ports as a reset pulse of the wrong length. A lost done flag makes the pulse too long, a counter that restarts lengthens it after a re-write, and a premature clear makes it shorter than MIN_PULSE. Because the expected length is max(MIN_PULSE, D+1) cycles, sweeping D over each domain shows any such error on the first pulse it affects. Every sample also compares the read-back bits with the reset outputs, so a wrong bit shows up in the very cycle it goes wrong.

// File: rtl/sdhc_swrst_pkg.sv
package sdhc_swrst_pkg;

  localparam int NUM_DOM = 3;
  localparam int DOM_ALL = 0;
  localparam int DOM_CMD = 1;
  localparam int DOM_DAT = 2;

  // True once a reset that has run cnt+1 cycles has met the minimum length.
  function automatic logic min_elapsed(input int unsigned cnt, input int unsigned min_pulse);
    return (cnt + 1) >= min_pulse;
  endfunction

  // Status bits as seen by software: the full reset overlays both line domains.
  function automatic logic [NUM_DOM-1:0] status_bits(input logic [NUM_DOM-1:0] busy);
    logic [NUM_DOM-1:0] s;
    s[DOM_ALL] = busy[DOM_ALL];
    s[DOM_CMD] = busy[DOM_CMD] | busy[DOM_ALL];
    s[DOM_DAT] = busy[DOM_DAT] | busy[DOM_ALL];
    return s;
  endfunction

endpackage

// File: rtl/sdhc_rst_domain.sv
module sdhc_rst_domain
  import sdhc_swrst_pkg::*;
#(
  parameter int MIN_PULSE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic done_i,
  output logic busy_o,
  output logic start_o,
  output logic finish_o
);

  localparam int CNT_W = (MIN_PULSE > 2) ? $clog2(MIN_PULSE) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_PULSE - 1);

  logic             busy_q;
  logic             seen_q;
  logic [CNT_W-1:0] cnt_q;
  logic             start_ok;
  logic             finish;

  // A request while busy is dropped: no restart, no extension.
  assign start_ok = start_req & ~busy_q;
  assign finish   = busy_q & min_elapsed(int'(cnt_q), MIN_PULSE) & (seen_q | done_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      seen_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_ok) begin
      busy_q <= 1'b1;
      seen_q <= 1'b0;
      cnt_q  <= '0;
    end else if (finish) begin
      busy_q <= 1'b0;
      seen_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      if (done_i) seen_q <= 1'b1;
    end
  end

  assign busy_o   = busy_q;
  assign start_o  = start_ok;
  assign finish_o = finish;

endmodule

// File: rtl/sdhc_swrst_outmap.sv
module sdhc_swrst_outmap
  import sdhc_swrst_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic [NUM_DOM-1:0] dom_busy,
  input  logic               buf_rden_i,
  output logic [REG_W-1:0]   rd_data,
  output logic               rst_all_o,
  output logic               rst_cmd_o,
  output logic               rst_dat_o,
  output logic               dma_rst_o,
  output logic               buf_rden_o
);

  localparam int RSVD_W = REG_W - NUM_DOM;

  logic [NUM_DOM-1:0] status;

  assign status = status_bits(dom_busy);

  generate
    if (RSVD_W > 0) begin : g_rsvd
      assign rd_data = {{RSVD_W{1'b0}}, status};
    end else begin : g_norsvd
      assign rd_data = status[REG_W-1:0];
    end
  endgenerate

  assign rst_all_o  = status[DOM_ALL];
  assign rst_cmd_o  = status[DOM_CMD];
  assign rst_dat_o  = status[DOM_DAT];
  assign dma_rst_o  = status[DOM_DAT];
  assign buf_rden_o = buf_rden_i & ~status[DOM_DAT];

endmodule

// File: rtl/sdhc_swrst_ctrl.sv
module sdhc_swrst_ctrl
  import sdhc_swrst_pkg::*;
#(
  parameter int REG_W     = 8,
  parameter int MIN_PULSE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             all_done_i,
  input  logic             cmd_done_i,
  input  logic             dat_done_i,
  input  logic             buf_rden_i,
  output logic             rst_all_o,
  output logic             rst_cmd_o,
  output logic             rst_dat_o,
  output logic             dma_rst_o,
  output logic             buf_rden_o
);

  logic [NUM_DOM-1:0] done_vec;
  logic [NUM_DOM-1:0] dom_busy;
  logic [NUM_DOM-1:0] dom_start;
  logic [NUM_DOM-1:0] dom_finish;
  logic               rsvd_unused;

  assign done_vec[DOM_ALL] = all_done_i;
  assign done_vec[DOM_CMD] = cmd_done_i;
  assign done_vec[DOM_DAT] = dat_done_i;
  assign rsvd_unused       = ^wr_data[REG_W-1:NUM_DOM];

  generate
    for (genvar g = 0; g < NUM_DOM; g++) begin : g_dom
      sdhc_rst_domain #(.MIN_PULSE(MIN_PULSE)) u_dom (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_req(wr_en & wr_data[g]),
        .done_i   (done_vec[g]),
        .busy_o   (dom_busy[g]),
        .start_o  (dom_start[g]),
        .finish_o (dom_finish[g])
      );
    end
  endgenerate

  sdhc_swrst_outmap #(.REG_W(REG_W)) u_map (
    .dom_busy  (dom_busy),
    .buf_rden_i(buf_rden_i),
    .rd_data   (rd_data),
    .rst_all_o (rst_all_o),
    .rst_cmd_o (rst_cmd_o),
    .rst_dat_o (rst_dat_o),
    .dma_rst_o (dma_rst_o),
    .buf_rden_o(buf_rden_o)
  );

endmodule

// File: rtl/sdhc_swrst_chk.sv
module sdhc_swrst_chk
  import sdhc_swrst_pkg::*;
#(
  parameter int REG_W     = 8,
  parameter int MIN_PULSE = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [REG_W-1:0]   wr_data,
  input logic [REG_W-1:0]   rd_data,
  input logic [NUM_DOM-1:0] done_vec,
  input logic [NUM_DOM-1:0] dom_busy,
  input logic               rst_all_o,
  input logic               rst_dat_o,
  input logic               dma_rst_o,
  input logic               buf_rden_o
);

  logic [15:0]        len_q [NUM_DOM];
  logic [NUM_DOM-1:0] seen_q;

  for (genvar i = 0; i < NUM_DOM; i++) begin : g_track
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        len_q[i]  <= '0;
        seen_q[i] <= 1'b0;
      end else begin
        if (dom_busy[i]) len_q[i] <= (len_q[i] == 16'hFFFF) ? len_q[i] : len_q[i] + 16'd1;
        else             len_q[i] <= '0;
        seen_q[i] <= dom_busy[i] ? (seen_q[i] | done_vec[i]) : 1'b0;
      end
    end

    // R1
    start_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[i] && !dom_busy[i]) |=> (dom_busy[i] && rd_data[i]));

    // R2
    min_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dom_busy[i]) |-> (len_q[i] >= 16'(MIN_PULSE)));

    // R3
    done_before_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dom_busy[i]) |-> seen_q[i]);

    // R3 R7
    clear_timely_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dom_busy[i] && (len_q[i] + 16'd1 >= 16'(MIN_PULSE)) && (seen_q[i] || done_vec[i]))
        |=> !dom_busy[i]);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!dom_busy[i] && !(wr_en && wr_data[i])) |=> !dom_busy[i]);
  end

  // R5
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[REG_W-1:NUM_DOM] == '0);

  // R4
  dat_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_dat_o |-> (dma_rst_o && !buf_rden_o));

  // R6
  full_overlay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_all_o |-> (rd_data[NUM_DOM-1:0] == {NUM_DOM{1'b1}}));

endmodule

bind sdhc_swrst_ctrl sdhc_swrst_chk #(.REG_W(REG_W), .MIN_PULSE(MIN_PULSE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .rd_data   (rd_data),
  .done_vec  (done_vec),
  .dom_busy  (dom_busy),
  .rst_all_o (rst_all_o),
  .rst_dat_o (rst_dat_o),
  .dma_rst_o (dma_rst_o),
  .buf_rden_o(buf_rden_o)
);

// File: tb/sim_sdhc_swrst_ctrl.sv
`timescale 1ns/1ps
module sim_sdhc_swrst_ctrl;

  localparam int MINP = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       all_done_i = 1'b0, cmd_done_i = 1'b0, dat_done_i = 1'b0;
  logic       buf_rden_i = 1'b1;
  logic       rst_all_o, rst_cmd_o, rst_dat_o, dma_rst_o, buf_rden_o;

  int total = 0;
  int fails = 0;
  int cyc   = 0;

  always #2.5 clk = ~clk;

  sdhc_swrst_ctrl #(.REG_W(8), .MIN_PULSE(MINP)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .all_done_i(all_done_i), .cmd_done_i(cmd_done_i), .dat_done_i(dat_done_i),
    .buf_rden_i(buf_rden_i), .rst_all_o(rst_all_o), .rst_cmd_o(rst_cmd_o),
    .rst_dat_o(rst_dat_o), .dma_rst_o(dma_rst_o), .buf_rden_o(buf_rden_o)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      total++; fails++;
      $display("FAIL watchdog: actual cycles %0d expected < 20000", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int expect_len(input int d);
    return (d + 1 > MINP) ? d + 1 : MINP;
  endfunction

  // Write mask, then count cycles each reset output stays high.
  // d*: sample index at which that done input pulses (-1 never).
  task automatic run_seq(input logic [7:0] mask, input int d0, input int d1, input int d2,
                         input int rw_k, input logic [7:0] rw_data,
                         output int c_all, output int c_cmd, output int c_dat, output int mism);
    c_all = 0; c_cmd = 0; c_dat = 0; mism = 0;
    @(negedge clk);
    wr_en = 1'b1; wr_data = mask;
    @(negedge clk);
    for (int k = 0; k < 60; k++) begin
      wr_en      = (k == rw_k);
      wr_data    = (k == rw_k) ? rw_data : 8'h00;
      all_done_i = (k == d0);
      cmd_done_i = (k == d1);
      dat_done_i = (k == d2);
      #1;
      if (rd_data != {5'b0, rst_dat_o, rst_cmd_o, rst_all_o}) mism++;
      if (dma_rst_o != rst_dat_o) mism++;
      if (buf_rden_o != (buf_rden_i & ~rst_dat_o)) mism++;
      if (!rst_all_o && !rst_cmd_o && !rst_dat_o) break;
      c_all += int'(rst_all_o);
      c_cmd += int'(rst_cmd_o);
      c_dat += int'(rst_dat_o);
      @(negedge clk);
    end
    wr_en = 1'b0; wr_data = '0;
    all_done_i = 1'b0; cmd_done_i = 1'b0; dat_done_i = 1'b0;
  endtask

  initial begin
    int ca, cc, cd, mm, got;
    repeat (3) @(negedge clk);
    #1;
    // R5 reset state
    chk(rd_data == 8'h00, "R5 reset read", int'(rd_data), 0);
    chk({rst_all_o, rst_cmd_o, rst_dat_o, dma_rst_o} == 4'b0, "R5 reset outputs",
        int'({rst_all_o, rst_cmd_o, rst_dat_o, dma_rst_o}), 0);
    rst_n = 1'b1;

    // R1 R5 writing zeros and reserved bits starts nothing
    @(negedge clk); wr_en = 1'b1; wr_data = 8'hF8;
    @(negedge clk); wr_en = 1'b0; wr_data = 8'h00; #1;
    chk(rd_data == 8'h00, "R5 reserved write ignored", int'(rd_data), 0);
    chk(!rst_all_o && !rst_cmd_o && !rst_dat_o, "R1 zero bits start nothing",
        int'({rst_all_o, rst_cmd_o, rst_dat_o}), 0);

    // R9 done inputs while idle
    @(negedge clk); all_done_i = 1'b1; cmd_done_i = 1'b1; dat_done_i = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(rd_data == 8'h00 && !rst_cmd_o, "R9 idle done ignored", int'(rd_data), 0);
    all_done_i = 1'b0; cmd_done_i = 1'b0; dat_done_i = 1'b0;

    // R1 R2 R3 R6 sweep over domain and done delay
    for (int dom = 0; dom < 3; dom++) begin
      for (int d = 0; d < 8; d++) begin
        run_seq(8'(1 << dom), (dom == 0) ? d : -1, (dom == 1) ? d : -1, (dom == 2) ? d : -1,
                -1, 8'h00, ca, cc, cd, mm);
        got = (dom == 0) ? ca : (dom == 1) ? cc : cd;
        chk(got == expect_len(d), $sformatf("R2 R3 dom%0d done@%0d length", dom, d),
            got, expect_len(d));
        if (dom == 0)
          chk(cc == ca && cd == ca, "R6 full reset overlays line outputs", cc + cd, 2 * ca);
        chk(mm == 0, "R1 R4 R5 read-back matches outputs", mm, 0);
      end
    end

    // R9 done while idle does not shorten a later reset
    @(negedge clk); cmd_done_i = 1'b1;
    @(negedge clk); cmd_done_i = 1'b0;
    run_seq(8'h02, -1, 5, -1, -1, 8'h00, ca, cc, cd, mm);
    chk(cc == 6, "R9 earlier idle done not remembered", cc, 6);

    // R7 re-write while busy does not restart
    run_seq(8'h02, -1, 3, -1, 2, 8'h02, ca, cc, cd, mm);
    chk(cc == MINP, "R7 cmd re-write no restart", cc, MINP);
    run_seq(8'h04, -1, -1, 3, 1, 8'h04, ca, cc, cd, mm);
    chk(cd == MINP, "R7 dat re-write no restart", cd, MINP);

    // R8 simultaneous start, independent clear
    run_seq(8'h06, -1, 1, 7, -1, 8'h00, ca, cc, cd, mm);
    chk(cc == 4, "R8 cmd clears on own done", cc, 4);
    chk(cd == 8, "R8 dat clears on own done", cd, 8);

    // R6 R8 full plus command together
    run_seq(8'h03, 2, 8, -1, -1, 8'h00, ca, cc, cd, mm);
    chk(ca == 4, "R6 full bit clears on all_done_i", ca, 4);
    chk(cc == 9, "R8 cmd outlives full reset", cc, 9);
    chk(cd == 4, "R6 dat follows full reset", cd, 4);
    chk(mm == 0, "R6 read-back during overlap", mm, 0);

    // R4 buffer read enable passes through when idle, forced low during data reset
    @(negedge clk); wr_en = 1'b1; wr_data = 8'h04;
    @(negedge clk); wr_en = 1'b0; wr_data = 8'h00; #1;
    chk(!buf_rden_o && dma_rst_o, "R4 data reset blocks read enable",
        int'({buf_rden_o, dma_rst_o}), 1);
    dat_done_i = 1'b1;
    repeat (MINP) @(negedge clk);
    dat_done_i = 1'b0; #1;
    chk(buf_rden_o && !dma_rst_o, "R4 read enable restored after reset",
        int'({buf_rden_o, dma_rst_o}), 2);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule